// File: doc/BRIEF.md
# Timer with watchdog

A single-channel timer block controlled through three words on a plain 32-bit register bus (a mode word, a period word and a status word) plus a read-only capture word. A prescaler divides the input clock. Each time it wraps, a counter steps toward a terminal value. When the counter reaches that value, the block either stops (one-shot) or reloads (continuous), and it raises an event flag. The same counter can act as a watchdog. In that role, reaching the terminal value gives a one-clock reset pulse instead of an event. Software holds the reset off by writing a fixed key byte into the top byte of the mode word.

The timer pin is split into an input, an output value and an output enable. In the general-purpose I/O function the block drives the pin or leaves it as an input. A synchronized copy of the pin level can always be read from the status word. In the capture function a chosen pin edge (rising, falling or both) copies the running counter into the capture word and raises a second event flag. The flags are cleared by writing ones to them. The interrupt output is high while any flag is set and interrupts are enabled.

Register map (word index on `bus_addr`): 0 mode, 1 period, 2 status, 3 capture (read-only). Mode fields: [2:0] function (0 none, 1 capture, 2 and 3 accepted but inert, 4 general-purpose I/O), [5:4] pin control, [8] interrupt enable, [10] continuous, [12] run, [15] watchdog, [17:16] capture edge. Period word: [31:16] prescale, [15:0] terminal count. Status: [3:0] flags (bit 0 terminal, bit 1 capture), [8] pin level. Capture word: [15:0] captured counter.

Top module: `periodic_timer_unit`

## Requirements
- R1: After reset the mode word, status flags, capture word, `irq`, `wdt_rst` and `pin_oe` are all zero.
- R2: With run set, continuous clear and watchdog clear, status flag 0 rises exactly P×T clock edges after the write that set run, where P is the prescale and T the terminal count. At that same edge run clears, so the mode word reads back with bit 12 low.
- R3: With continuous set, flag 0 is raised every P×T edges and run stays set.
- R4: A prescale field of 0 acts as 65536. The prescaler never holds a value at or above its limit.
- R5: Writing a one to a status flag bit clears that flag. Writing a zero leaves it unchanged.
- R6: `irq` is high exactly when a flag is set, mode bit 8 is set and mode bit 15 is clear.
- R7: With bits 12 and 15 both set, reaching the terminal count drives `wdt_rst` high for one clock when P×T is at least 2. Flag 0 is not set in this case.
- R8: A mode write whose byte enable 3 is set and whose bits [31:24] equal 0xA5 changes no mode bit. If the watchdog is armed, that write restarts the countdown from zero. Otherwise it has no effect on the timing.
- R9: While bits 12 and 15 are both set, a mode write keeps both set unless it clears both of them in the same write.
- R10: With function 4, pin control 2 drives the pin low and pin control 3 drives it high (`pin_oe`=1). Any other pin control, and every other function, leaves `pin_oe`=0.
- R11: Status bit 8 shows the level on `pin_i` two clock edges after that level is applied.
- R12: With function 1, a pin edge that matches mode[17:16] (1 rising, 2 falling, 3 either) stores the counter value into the capture word and sets flag 1. This happens three edges after the pin changes. A pin edge that does not match changes neither the flag nor the capture word.
- R13: The mode word reads back only its defined fields. Bytes of the mode word whose byte enable is low keep their old value. The period word reads back exactly as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Word index: 0 mode, 1 period, 2 status, 3 capture |
| bus_be | input | 4 | Byte lane enables for mode writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word (combinational) |
| pin_i | input | 1 | Timer pin input level |
| pin_o | output | 1 | Timer pin output value |
| pin_oe | output | 1 | Timer pin output enable |
| irq | output | 1 | Interrupt request |
| wdt_rst | output | 1 | Watchdog reset pulse |

## Verification
The hardest state to reach from the ports is a watchdog service arriving at a known counter phase. The bench has to show that the countdown restarts and is not merely left untouched. To do this it counts edges from the arming write, places a key write carrying all-ones in its other bytes two edges before the unserviced expiry, and confirms that no pulse appears at the old expiry but one does appear a full period after the key write. Capture values are checked in the same way. The bench counts edges from the run write, so the stored counter value is known exactly for each edge type and trigger selection.

// File: rtl/ptu_pkg.sv
package ptu_pkg;

    localparam int DATA_W    = 32;
    localparam int PSC_W     = 16;
    localparam int CNT_W     = 16;
    localparam int FLAG_W    = 4;
    localparam int ADDR_W    = 2;

    localparam int MB_FUNC   = 0;
    localparam int MB_PIN    = 4;
    localparam int MB_IRQ    = 8;
    localparam int MB_CONT   = 10;
    localparam int MB_RUN    = 12;
    localparam int MB_WD     = 15;
    localparam int MB_EDGE   = 16;
    localparam int KEY_LANE  = 3;
    localparam logic [7:0] SVC_KEY = 8'hA5;

    localparam int FLAG_TERM = 0;
    localparam int FLAG_CAPT = 1;
    localparam int STAT_PIN  = 8;

    localparam logic [ADDR_W-1:0] A_MODE   = 2'd0;
    localparam logic [ADDR_W-1:0] A_PERIOD = 2'd1;
    localparam logic [ADDR_W-1:0] A_STATUS = 2'd2;
    localparam logic [ADDR_W-1:0] A_CAPT   = 2'd3;

    typedef enum logic [2:0] {
        FN_NONE    = 3'd0,
        FN_CAPTURE = 3'd1,
        FN_COMPARE = 3'd2,
        FN_WAVE    = 3'd3,
        FN_GPIO    = 3'd4,
        FN_RSV5    = 3'd5,
        FN_RSV6    = 3'd6,
        FN_RSV7    = 3'd7
    } fn_e;

    typedef enum logic [1:0] {
        PC_INPUT  = 2'd0,
        PC_INPUT1 = 2'd1,
        PC_LOW    = 2'd2,
        PC_HIGH   = 2'd3
    } pinctl_e;

    typedef enum logic [1:0] {
        ED_NONE = 2'd0,
        ED_RISE = 2'd1,
        ED_FALL = 2'd2,
        ED_BOTH = 2'd3
    } edge_e;

    typedef struct packed {
        edge_e   edge_sel;
        logic    wd_en;
        logic    run;
        logic    cont;
        logic    irq_en;
        pinctl_e pin_ctl;
        fn_e     func;
    } mode_t;

    typedef struct packed {
        logic [PSC_W-1:0] presc;
        logic [CNT_W-1:0] term;
    } period_t;

    function automatic mode_t mode_unpack(input logic [DATA_W-1:0] w);
        mode_t m;
        m.func     = fn_e'(w[MB_FUNC +: 3]);
        m.pin_ctl  = pinctl_e'(w[MB_PIN +: 2]);
        m.irq_en   = w[MB_IRQ];
        m.cont     = w[MB_CONT];
        m.run      = w[MB_RUN];
        m.wd_en    = w[MB_WD];
        m.edge_sel = edge_e'(w[MB_EDGE +: 2]);
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] mode_pack(input mode_t m);
        logic [DATA_W-1:0] w;
        w = '0;
        w[MB_FUNC +: 3] = m.func;
        w[MB_PIN +: 2]  = m.pin_ctl;
        w[MB_IRQ]       = m.irq_en;
        w[MB_CONT]      = m.cont;
        w[MB_RUN]       = m.run;
        w[MB_WD]        = m.wd_en;
        w[MB_EDGE +: 2] = m.edge_sel;
        return w;
    endfunction

    function automatic logic edge_match(input edge_e sel, input logic rise, input logic fall);
        return (sel[0] & rise) | (sel[1] & fall);
    endfunction

endpackage

// File: rtl/ptu_counter.sv
module ptu_counter
    import ptu_pkg::*;
#(
    parameter int P_W = PSC_W,
    parameter int C_W = CNT_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           run,
    input  logic           restart,
    input  logic [P_W-1:0] presc,
    input  logic [C_W-1:0] term,
    output logic           term_hit,
    output logic [C_W-1:0] cnt_val
);

    logic [P_W-1:0] pre_q;
    logic [C_W-1:0] cnt_q;
    logic [P_W-1:0] pre_last;
    logic [C_W-1:0] cnt_last;
    logic           tick;

    // A zero field wraps to all ones here, giving a 2**W cycle limit.
    assign pre_last = presc - P_W'(1);
    assign cnt_last = term - C_W'(1);
    assign tick     = run && (pre_q == pre_last);
    assign term_hit = tick && (cnt_q == cnt_last);
    assign cnt_val  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
            cnt_q <= term_hit ? '0 : cnt_q + C_W'(1);
        end else begin
            pre_q <= pre_q + P_W'(1);
        end
    end

    assert_psc_bound_R4 : assert property (@(posedge clk) disable iff (rst)
        pre_q <= pre_last);

    assert_cnt_bound_R2 : assert property (@(posedge clk) disable iff (rst)
        cnt_q <= cnt_last);

endmodule

// File: rtl/ptu_pin.sv
module ptu_pin
    import ptu_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  pin_i,
    input  mode_t mode,
    output logic  pin_o,
    output logic  pin_oe,
    output logic  pin_lvl,
    output logic  capt_evt
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   rise;
    logic                   fall;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= pin_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
            end
        end
    endgenerate

    assign pin_lvl = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= pin_lvl;
    end

    assign rise     = pin_lvl & ~prev_q;
    assign fall     = ~pin_lvl & prev_q;
    assign capt_evt = (mode.func == FN_CAPTURE) && edge_match(mode.edge_sel, rise, fall);

    always_comb begin
        pin_oe = 1'b0;
        pin_o  = 1'b0;
        if (mode.func == FN_GPIO) begin
            unique case (mode.pin_ctl)
                PC_LOW:  begin pin_oe = 1'b1; pin_o = 1'b0; end
                PC_HIGH: begin pin_oe = 1'b1; pin_o = 1'b1; end
                default: begin pin_oe = 1'b0; pin_o = 1'b0; end
            endcase
        end
    end

    assert_capt_on_change_R12 : assert property (@(posedge clk) disable iff (rst)
        capt_evt |-> (pin_lvl != prev_q));

endmodule

// File: rtl/ptu_regs.sv
module ptu_regs
    import ptu_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [3:0]          bus_be,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                term_hit,
    input  logic                capt_evt,
    input  logic [CNT_W-1:0]    capt_val,
    input  logic                pin_lvl,
    output mode_t               mode_q,
    output period_t             period_q,
    output logic                cnt_restart,
    output logic                irq,
    output logic                wdt_rst
);

    logic [FLAG_W-1:0] flags_q;
    logic [CNT_W-1:0]  capt_q;
    logic              wr_mode;
    logic              wr_period;
    logic              wr_status;
    logic              svc_wr;
    logic              armed;
    logic              stop_both;
    logic [DATA_W-1:0] merged;
    mode_t             mode_new;
    mode_t             mode_d;
    logic [FLAG_W-1:0] set_vec;
    logic [FLAG_W-1:0] clr_vec;

    assign wr_mode   = bus_wr && (bus_addr == A_MODE);
    assign wr_period = bus_wr && (bus_addr == A_PERIOD);
    assign wr_status = bus_wr && (bus_addr == A_STATUS);
    assign svc_wr    = wr_mode && bus_be[KEY_LANE] && (bus_wdata[KEY_LANE*8 +: 8] == SVC_KEY);
    assign armed     = mode_q.wd_en && mode_q.run;

    // Lanes 0..2 hold mode fields; lane 3 only ever carries the key.
    always_comb begin
        merged = mode_pack(mode_q);
        for (int i = 0; i < KEY_LANE; i++) begin
            if (bus_be[i]) merged[i*8 +: 8] = bus_wdata[i*8 +: 8];
        end
        mode_new  = mode_unpack(merged);
        stop_both = !mode_new.wd_en && !mode_new.run;
        if (armed && !stop_both) begin
            mode_new.wd_en = 1'b1;
            mode_new.run   = 1'b1;
        end
    end

    always_comb begin
        mode_d = mode_q;
        if (wr_mode && !svc_wr) begin
            mode_d = mode_new;
        end else if (term_hit && !mode_q.cont && !mode_q.wd_en) begin
            mode_d.run = 1'b0;
        end
    end

    assign cnt_restart = (svc_wr && armed) || wr_period;

    always_comb begin
        set_vec            = '0;
        set_vec[FLAG_TERM] = term_hit && !mode_q.wd_en;
        set_vec[FLAG_CAPT] = capt_evt;
        clr_vec            = wr_status ? bus_wdata[FLAG_W-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= mode_unpack('0);
            period_q <= '0;
            flags_q  <= '0;
            capt_q   <= '0;
            wdt_rst  <= 1'b0;
        end else begin
            mode_q  <= mode_d;
            if (wr_period) period_q <= period_t'(bus_wdata);
            flags_q <= (flags_q & ~clr_vec) | set_vec;
            if (capt_evt) capt_q <= capt_val;
            wdt_rst <= term_hit && mode_q.wd_en;
        end
    end

    assign irq = (|flags_q) && mode_q.irq_en && !mode_q.wd_en;

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_MODE:   bus_rdata = mode_pack(mode_q);
            A_PERIOD: bus_rdata = period_q;
            A_STATUS: begin
                bus_rdata[FLAG_W-1:0] = flags_q;
                bus_rdata[STAT_PIN]   = pin_lvl;
            end
            A_CAPT:   bus_rdata[CNT_W-1:0] = capt_q;
            default:  bus_rdata = '0;
        endcase
    end

    assert_oneshot_stops_R2 : assert property (@(posedge clk) disable iff (rst)
        term_hit && !mode_q.cont && !mode_q.wd_en && !wr_mode |=> !mode_q.run);

    assert_w1c_R5 : assert property (@(posedge clk) disable iff (rst)
        wr_status && bus_wdata[FLAG_TERM] && !set_vec[FLAG_TERM] |=> !flags_q[FLAG_TERM]);

    assert_key_keeps_mode_R8 : assert property (@(posedge clk) disable iff (rst)
        svc_wr && mode_q.wd_en |=> $stable(mode_q));

    assert_wd_lock_R9 : assert property (@(posedge clk) disable iff (rst)
        armed && !(wr_mode && !svc_wr && stop_both) |=> (mode_q.wd_en && mode_q.run));

endmodule

// File: rtl/periodic_timer_unit.sv
module periodic_timer_unit
    import ptu_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [3:0]  bus_be,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        pin_i,
    output logic        pin_o,
    output logic        pin_oe,
    output logic        irq,
    output logic        wdt_rst
);

    mode_t            mode_q;
    period_t          period_q;
    logic             cnt_restart;
    logic             term_hit;
    logic [CNT_W-1:0] cnt_val;
    logic             pin_lvl;
    logic             capt_evt;

    ptu_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_be      (bus_be),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .term_hit    (term_hit),
        .capt_evt    (capt_evt),
        .capt_val    (cnt_val),
        .pin_lvl     (pin_lvl),
        .mode_q      (mode_q),
        .period_q    (period_q),
        .cnt_restart (cnt_restart),
        .irq         (irq),
        .wdt_rst     (wdt_rst)
    );

    ptu_counter #(
        .P_W (PSC_W),
        .C_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run      (mode_q.run),
        .restart  (cnt_restart),
        .presc    (period_q.presc),
        .term     (period_q.term),
        .term_hit (term_hit),
        .cnt_val  (cnt_val)
    );

    ptu_pin #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_pin (
        .clk      (clk),
        .rst      (rst),
        .pin_i    (pin_i),
        .mode     (mode_q),
        .pin_o    (pin_o),
        .pin_oe   (pin_oe),
        .pin_lvl  (pin_lvl),
        .capt_evt (capt_evt)
    );

    assert_wd_pulse_source_R7 : assert property (@(posedge clk) disable iff (rst)
        wdt_rst |-> $past(mode_q.wd_en && mode_q.run));

    assert_irq_quiet_in_wd_R6 : assert property (@(posedge clk) disable iff (rst)
        $rose(mode_q.wd_en) |-> !irq);

endmodule

// File: tb/sim_periodic_timer_unit.sv
`timescale 1ns/100ps
module sim_periodic_timer_unit;

    localparam logic [1:0] RM = 2'd0, RP = 2'd1, RS = 2'd2, RC = 2'd3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [3:0]  bus_be = 4'hF;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pin_i = 1'b0;
    logic        pin_o, pin_oe, irq, wdt_rst;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    periodic_timer_unit u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_i(pin_i), .pin_o(pin_o),
        .pin_oe(pin_oe), .irq(irq), .wdt_rst(wdt_rst)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired (all requirements) actual=%0d expected=<190000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_be    = be;
        bus_wr    = 1'b1;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
        bus_be = 4'hF;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.1;
        d = bus_rdata;
    endtask

    initial begin
        logic [31:0] v;
        logic [31:0] last_cap;
        bit          seen;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;

        // R1 reset state
        rd(RM, v); check("R1 mode after reset", v, 32'h0);
        rd(RS, v); check("R1 status after reset", v, 32'h0);
        rd(RC, v); check("R1 capture after reset", v, 32'h0);
        check("R1 irq/wdt_rst/pin_oe after reset", {29'd0, irq, wdt_rst, pin_oe}, 32'h0);

        // R13 layout and byte lanes
        wr(RM, 32'hFFFF_FFFF, 4'b0001);
        rd(RM, v); check("R13 lane 0 only", v, 32'h0000_0037);
        wr(RM, 32'h0003_0537);
        rd(RM, v); check("R13 defined fields", v, 32'h0003_0537);
        wr(RM, 32'h0);
        wr(RP, 32'h1234_5678);
        rd(RP, v); check("R13 period readback", v, 32'h1234_5678);

        // R2/R4 one-shot sweep over prescale and terminal
        for (int p = 1; p <= 3; p++) begin
            for (int t = 1; t <= 4; t++) begin
                wr(RP, (p << 16) | t);
                wr(RS, 32'hF);
                wr(RM, 32'h1000);
                repeat (p*t - 1) @(posedge clk);
                #1;
                rd(RS, v); check($sformatf("R2 flag early p=%0d t=%0d", p, t), {31'd0, v[0]}, 32'd0);
                @(posedge clk);
                #1;
                rd(RS, v); check($sformatf("R4 R2 flag on time p=%0d t=%0d", p, t), {31'd0, v[0]}, 32'd1);
                rd(RM, v); check($sformatf("R2 run cleared p=%0d t=%0d", p, t), v, 32'h0);
                check("R6 irq off without enable", {31'd0, irq}, 32'd0);
            end
        end

        // R3 continuous
        wr(RP, 32'h0002_0003);
        wr(RS, 32'hF);
        wr(RM, 32'h1400);
        repeat (6) @(posedge clk);
        #1;
        rd(RS, v); check("R3 first period", {31'd0, v[0]}, 32'd1);
        wr(RS, 32'h1);
        repeat (4) @(posedge clk);
        #1;
        rd(RS, v); check("R3 between periods", {31'd0, v[0]}, 32'd0);
        @(posedge clk);
        #1;
        rd(RS, v); check("R3 second period", {31'd0, v[0]}, 32'd1);
        rd(RM, v); check("R3 run stays", v, 32'h1400);
        wr(RM, 32'h0);

        // R5/R6 flags and interrupt
        wr(RM, 32'h0100);
        check("R6 irq with flag and enable", {31'd0, irq}, 32'd1);
        wr(RS, 32'h2);
        rd(RS, v); check("R5 zero bit keeps flag", {31'd0, v[0]}, 32'd1);
        wr(RM, 32'h8100);
        check("R6 irq masked by watchdog bit", {31'd0, irq}, 32'd0);
        wr(RM, 32'h0100);
        wr(RS, 32'h1);
        rd(RS, v); check("R5 one clears flag", {31'd0, v[0]}, 32'd0);
        check("R6 irq drops after clear", {31'd0, irq}, 32'd0);
        wr(RM, 32'h0);

        // R4 prescale zero means 65536
        wr(RP, 32'h0000_0001);
        wr(RS, 32'hF);
        wr(RM, 32'h1000);
        repeat (65535) @(posedge clk);
        #1;
        rd(RS, v); check("R4 zero prescale early", {31'd0, v[0]}, 32'd0);
        @(posedge clk);
        #1;
        rd(RS, v); check("R4 zero prescale at 65536", {31'd0, v[0]}, 32'd1);
        wr(RS, 32'hF);

        // R7 watchdog expiry
        wr(RP, 32'h0001_0004);
        wr(RM, 32'h9000);
        repeat (3) @(posedge clk);
        #1;
        check("R7 no pulse before expiry", {31'd0, wdt_rst}, 32'd0);
        @(posedge clk);
        #1;
        check("R7 pulse at expiry", {31'd0, wdt_rst}, 32'd1);
        rd(RS, v); check("R7 no flag in watchdog", {31'd0, v[0]}, 32'd0);
        @(posedge clk);
        #1;
        check("R7 pulse lasts one clock", {31'd0, wdt_rst}, 32'd0);

        // R8 service with key, other lanes all ones
        wr(RM, 32'hA5FF_FFFF);
        rd(RM, v); check("R8 key write keeps mode", v, 32'h9000);
        repeat (2) @(posedge clk);
        #1;
        check("R8 old expiry suppressed", {31'd0, wdt_rst}, 32'd0);
        @(posedge clk);
        #1;
        check("R8 still counting", {31'd0, wdt_rst}, 32'd0);
        @(posedge clk);
        #1;
        check("R8 expiry one period after key", {31'd0, wdt_rst}, 32'd1);

        // R9 lock
        wr(RM, 32'h1000);
        rd(RM, v); check("R9 clearing only watchdog bit", v, 32'h9000);
        wr(RM, 32'h8000);
        rd(RM, v); check("R9 clearing only run bit", v, 32'h9000);
        wr(RM, 32'h0);
        rd(RM, v); check("R9 clearing both stops", v, 32'h0);
        seen = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(posedge clk);
            #1;
            if (wdt_rst) seen = 1'b1;
        end
        check("R9 no pulse after stop", {31'd0, seen}, 32'd0);

        // R8 key outside watchdog mode
        wr(RP, 32'h0001_0006);
        wr(RS, 32'hF);
        wr(RM, 32'h1000);
        wr(RM, 32'hA500_0000);
        rd(RM, v); check("R8 key outside watchdog keeps mode", v, 32'h1000);
        repeat (4) @(posedge clk);
        #1;
        rd(RS, v); check("R8 key no restart early", {31'd0, v[0]}, 32'd0);
        @(posedge clk);
        #1;
        rd(RS, v); check("R8 key no restart on time", {31'd0, v[0]}, 32'd1);
        wr(RS, 32'hF);

        // R10 pin drive
        wr(RM, 32'h24);
        check("R10 drive low", {30'd0, pin_oe, pin_o}, 32'd2);
        wr(RM, 32'h34);
        check("R10 drive high", {30'd0, pin_oe, pin_o}, 32'd3);
        wr(RM, 32'h04);
        check("R10 input in io mode", {31'd0, pin_oe}, 32'd0);
        wr(RM, 32'h14);
        check("R10 pin control 1 is input", {31'd0, pin_oe}, 32'd0);
        wr(RM, 32'h31);
        check("R10 no drive in capture mode", {31'd0, pin_oe}, 32'd0);
        wr(RM, 32'h0);

        // R11 synchronized level
        @(negedge clk);
        pin_i = 1'b1;
        @(posedge clk);
        #1;
        rd(RS, v); check("R11 level after one edge", {31'd0, v[8]}, 32'd0);
        @(posedge clk);
        #1;
        rd(RS, v); check("R11 level after two edges", {31'd0, v[8]}, 32'd1);

        // R12 capture over edge selections and directions
        last_cap = 32'h0;
        for (int sel = 1; sel <= 3; sel++) begin
            for (int dir = 0; dir < 2; dir++) begin
                int  nwait;
                bit  hit;
                nwait = 3 + sel*2 + dir;
                hit = (dir == 0) ? sel[0] : sel[1];
                wr(RM, 32'h0);
                @(negedge clk);
                pin_i = (dir == 0) ? 1'b0 : 1'b1;
                repeat (4) @(posedge clk);
                wr(RS, 32'hF);
                wr(RP, 32'h0001_0000);
                wr(RM, (sel << 16) | 32'h1001);
                repeat (nwait) @(posedge clk);
                @(negedge clk);
                pin_i = ~pin_i;
                repeat (3) @(posedge clk);
                #1;
                if (hit) last_cap = nwait + 2;
                rd(RS, v); check($sformatf("R12 flag sel=%0d dir=%0d", sel, dir), {31'd0, v[1]}, {31'd0, hit});
                rd(RC, v); check($sformatf("R12 capture sel=%0d dir=%0d", sel, dir), v, last_cap);
            end
        end
        wr(RM, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule